// File: doc/BRIEF.md
# External Interrupt Flag Unit

This block sits between eight external interrupt request lines and the core of a small microcontroller. Each line arrives already synchronized and carries a two-bit sense setting supplied from outside: low level, any change, falling edge or rising edge. For the three edge settings the block holds one pending flag per line. The flag is set when the selected transition appears on the sampled input. It is cleared by a one written over the register bus, by a per-line acknowledge pulse when the core takes the vector, or unconditionally while the line is in level setting.

A per-line enable mask and a global enable input gate the pending state into a registered request vector. A line in level setting skips the flag and requests for as long as its input is low. Lines 3 to 0 also model the input-buffer shutdown that comes with sleep. While the sleep input is high and such a line's mask bit is zero, the line is read as zero. The falling step this produces may set the flag. The flags can be read at byte address 0x1C on a simple single-cycle register bus.

Top module: `ext_irq_flags`

## Requirements
- R1: While reset is high and in the cycle after it, all flags, `irq_o` and `bus_rdata_o` are zero.
- R2: Sense code 01 (any change), 10 (falling) and 11 (rising) for line i sit in `sense_i[2i+1:2i]`. In these settings, flag i is set at the clock edge where the sampled input differs from the previous cycle's sample in the selected direction. The first sample after reset is never treated as an edge.
- R3: `irq_o[i]` is one in a cycle only if `gie_i` and `mask_i[i]` were both one in the previous cycle. It then equals the previous cycle's pending state of line i.
- R4: An `ack_i[i]` pulse clears flag i at the next clock edge.
- R5: A bus write (`bus_wr_i`) to address 0x1C clears each flag whose `bus_wdata_i` bit is one. Zero bits, and writes to any other address, leave the flags unchanged.
- R6: With sense code 00 (low level), flag i is forced to zero. The pending state of the line is then its sampled input being low.
- R7: For lines 3 to 0 only, while `sleep_i` is one and `mask_i[i]` is zero, the input is treated as zero both for edge detection and for the level setting.
- R8: When a set event and a clear (write or acknowledge) for the same flag occur in one cycle, the flag ends up set.
- R9: A bus read (`bus_rd_i`) at address 0x1C returns the flag byte (bit i = line i) on `bus_rdata_o` one cycle later. Any other read address, or no read, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Synchronized interrupt input lines |
| sense_i | input | 16 | Two-bit sense setting per line |
| sleep_i | input | 1 | Core is in sleep |
| mask_i | input | 8 | Per-line interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 8 | Per-line vector-taken pulse |
| bus_addr_i | input | 8 | Register bus address |
| bus_wr_i | input | 1 | Register bus write strobe |
| bus_rd_i | input | 1 | Register bus read strobe |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_rdata_o | output | 8 | Register bus read data, one cycle after the read |
| irq_o | output | 8 | Registered per-line interrupt request |

## Verification
The hardest case to reach is the flag set caused by sleep alone on lines 3 to 0. This needs a line held high with a falling sense setting and a zero mask bit, then sleep raised with no pin movement. The bench builds exactly that state and then reads the flags, which shows the lower nibble set and the upper nibble untouched. A second hard case puts a set event in the same cycle as a write-one and an acknowledge for that line. The bench reaches it by raising a rising-edge input in the cycle that carries both clears. A long phase of random inputs, checked against a behavioural model every clock, then covers the mixes of sense settings, mode switches and clears.

// File: rtl/eif_pkg.sv
package eif_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eif_input_gate.sv
module eif_input_gate #(
  parameter int N     = 8,
  parameter int GATED = 4
) (
  input  logic [N-1:0] pin_i,
  input  logic         sleep_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] smp_o
);
  // lines below GATED lose their input buffer in sleep when not enabled
  localparam logic [N-1:0] GATE_SEL = N'((64'd1 << GATED) - 64'd1);

  always_comb begin
    smp_o = pin_i & ~({N{sleep_i}} & ~mask_i & GATE_SEL);
  end
endmodule

// File: rtl/eif_edge_detect.sv
module eif_edge_detect
  import eif_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] sense_i,
  input  logic [N-1:0]   smp_i,
  output logic [N-1:0]   set_o,
  output logic [N-1:0]   level_o
);
  logic [N-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= smp_i;
      primed_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    sense_e mode;
    logic   rise, fall;
    always_comb begin
      mode       = sense_e'(sense_i[2*g +: 2]);
      rise       = primed_q & smp_i[g] & ~prev_q[g];
      fall       = primed_q & ~smp_i[g] & prev_q[g];
      level_o[g] = (mode == SENSE_LOW);
      unique case (mode)
        SENSE_ANY:  set_o[g] = rise | fall;
        SENSE_FALL: set_o[g] = fall;
        SENSE_RISE: set_o[g] = rise;
        default:    set_o[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/eif_flag_bank.sv
module eif_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] level_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_d;

  // set has priority over any clear; level setting forces zero
  always_comb begin
    flags_d = (set_i | (flags_o & ~clr_i)) & ~level_i;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= flags_d;
  end
endmodule

// File: rtl/eif_bus_port.sv
module eif_bus_port #(
  parameter int          N         = 8,
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h1C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      flags_i,
  output logic [N-1:0]      wclr_o,
  output logic [N-1:0]      rdata_o
);
  logic hit;

  always_comb begin
    hit    = (addr_i == FLAG_ADDR);
    wclr_o = (wr_i && hit) ? wdata_i : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)             rdata_o <= '0;
    else if (rd_i && hit) rdata_o <= flags_i;
    else                 rdata_o <= '0;
  end
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags #(
  parameter int          N         = 8,
  parameter int          GATED     = 4,
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h1C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pin_i,
  input  logic [2*N-1:0]    sense_i,
  input  logic              sleep_i,
  input  logic [N-1:0]      mask_i,
  input  logic              gie_i,
  input  logic [N-1:0]      ack_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [N-1:0]      bus_wdata_i,
  output logic [N-1:0]      bus_rdata_o,
  output logic [N-1:0]      irq_o
);
  logic [N-1:0] smp_w, set_w, level_w, wclr_w, flags_q, pend_w;

  eif_input_gate #(.N(N), .GATED(GATED)) u_gate (
    .pin_i(pin_i), .sleep_i(sleep_i), .mask_i(mask_i), .smp_o(smp_w)
  );

  eif_edge_detect #(.N(N)) u_edge (
    .clk(clk), .rst(rst), .sense_i(sense_i), .smp_i(smp_w),
    .set_o(set_w), .level_o(level_w)
  );

  eif_bus_port #(.N(N), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_bus (
    .clk(clk), .rst(rst), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
    .rd_i(bus_rd_i), .wdata_i(bus_wdata_i), .flags_i(flags_q),
    .wclr_o(wclr_w), .rdata_o(bus_rdata_o)
  );

  eif_flag_bank #(.N(N)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_w), .clr_i(wclr_w | ack_i),
    .level_i(level_w), .flags_o(flags_q)
  );

  always_comb begin
    pend_w = (level_w & ~smp_w) | (~level_w & flags_q);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= pend_w & mask_i & {N{gie_i}};
  end
endmodule

// File: rtl/eif_checker.sv
module eif_checker #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [2*N-1:0] sense_i,
  input logic [N-1:0]   mask_i,
  input logic           gie_i,
  input logic [N-1:0]   ack_i,
  input logic [N-1:0]   wclr,
  input logic [N-1:0]   set_w,
  input logic [N-1:0]   flags,
  input logic [N-1:0]   irq_o,
  input logic [N-1:0]   bus_rdata_o
);
  function automatic logic [N-1:0] low_sel(input logic [2*N-1:0] s);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (s[2*i +: 2] == 2'b00);
    return r;
  endfunction

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (flags == '0 && irq_o == '0 && bus_rdata_o == '0));

  assert_irq_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_o & ~($past(mask_i) & {N{$past(gie_i)}})) == '0);

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (flags & $past(ack_i & ~set_w)) == '0);

  assert_no_clear_without_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (~flags & $past(flags & ~wclr & ~ack_i & ~low_sel(sense_i))) == '0);

  assert_level_forces_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (flags & $past(low_sel(sense_i))) == '0);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    ((set_w & ~low_sel(sense_i)) != '0) |=>
      ((flags & $past(set_w & ~low_sel(sense_i))) == $past(set_w & ~low_sel(sense_i))));
endmodule

bind ext_irq_flags eif_checker #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .sense_i(sense_i), .mask_i(mask_i), .gie_i(gie_i),
  .ack_i(ack_i), .wclr(wclr_w), .set_w(set_w), .flags(flags_q),
  .irq_o(irq_o), .bus_rdata_o(bus_rdata_o)
);

// File: tb/ext_irq_flags_tb.sv
module ext_irq_flags_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin = '0, mask = '0, ack = '0, wdata = '0, addr = '0;
  logic [15:0] sense = '0;
  logic        sleep = 1'b0, gie = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata, irq;

  int total = 0, bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [7:0] m_flags, m_prev, m_irq, m_rdata;
  bit         m_primed;

  always #10 clk = ~clk;

  ext_irq_flags u_dut (
    .clk(clk), .rst(rst), .pin_i(pin), .sense_i(sense), .sleep_i(sleep),
    .mask_i(mask), .gie_i(gie), .ack_i(ack), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic model_edge();
    logic [7:0] s, nf, nirq, nrd;
    if (rst) begin
      m_flags = 0; m_prev = 0; m_irq = 0; m_rdata = 0; m_primed = 0;
      return;
    end
    for (int i = 0; i < 8; i++) begin
      int mode = sense[2*i +: 2];
      bit v = pin[i];
      bit r, f, setb, clr;
      if (i < 4 && sleep && !mask[i]) v = 0;
      s[i] = v;
      r = m_primed && v && !m_prev[i];
      f = m_primed && !v && m_prev[i];
      setb = (mode == 1) ? (r || f) : (mode == 2) ? f : (mode == 3) ? r : 0;
      clr = ack[i] || (wr && addr == 8'h1C && wdata[i]);
      if (mode == 0) nf[i] = 0;
      else if (setb) nf[i] = 1;
      else if (clr) nf[i] = 0;
      else nf[i] = m_flags[i];
      nirq[i] = gie && mask[i] && ((mode == 0) ? !v : m_flags[i]);
    end
    nrd = (rd && addr == 8'h1C) ? m_flags : 8'h00;
    m_flags = nf; m_prev = s; m_irq = nirq; m_rdata = nrd; m_primed = 1;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(cur_req, irq, m_irq, "irq");
    check(cur_req, rdata, m_rdata, "rdata");
  endtask

  task automatic idle();
    wr = 0; rd = 0; ack = 0; wdata = 0;
  endtask

  task automatic read_expect(string tag, logic [7:0] exp);
    idle(); rd = 1; addr = 8'h1C;
    step();
    check(tag, rdata, exp, "flag read");
    rd = 0;
  endtask

  task automatic clear_all();
    idle(); wr = 1; addr = 8'h1C; wdata = 8'hFF;
    step();
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_flags = 0; m_prev = 0; m_irq = 0; m_rdata = 0; m_primed = 0;
    repeat (3) step();
    @(negedge clk); rst = 0;
    cur_req = "R1";
    check("R1", irq, 8'h00, "irq after reset");
    check("R1", rdata, 8'h00, "rdata after reset");
    step();
    read_expect("R1", 8'h00);

    // R2 rising, falling, any change
    cur_req = "R2";
    sense = 16'hFFFF; pin = 8'h00; step(); step();
    pin = 8'h05; step();
    read_expect("R2", 8'h05);
    pin = 8'h00; step();
    read_expect("R2", 8'h05);
    clear_all();
    sense = 16'hAAAA; pin = 8'h30; step();
    pin = 8'h10; step();
    read_expect("R2", 8'h20);
    clear_all();
    sense = 16'h5555; pin = 8'h81; step();
    read_expect("R2", 8'h91);
    clear_all();

    // R9 wrong read address
    cur_req = "R9";
    sense = 16'hFFFF; pin = 8'h00; step();
    pin = 8'h40; step();
    idle(); rd = 1; addr = 8'h1D; step();
    check("R9", rdata, 8'h00, "read other address");
    read_expect("R9", 8'h40);

    // R5 write semantics
    cur_req = "R5";
    idle(); wr = 1; addr = 8'h1C; wdata = 8'h00; step();
    read_expect("R5", 8'h40);
    idle(); wr = 1; addr = 8'h3C; wdata = 8'hFF; step();
    read_expect("R5", 8'h40);
    idle(); wr = 1; addr = 8'h1C; wdata = 8'h40; step();
    read_expect("R5", 8'h00);

    // R3 gating of requests
    cur_req = "R3";
    pin = 8'h00; step();
    pin = 8'h02; step();
    gie = 0; mask = 8'hFF; step(); step();
    check("R3", irq, 8'h00, "gie off");
    gie = 1; mask = 8'h00; step(); step();
    check("R3", irq, 8'h00, "mask off");
    mask = 8'h02; step();
    check("R3", irq, 8'h02, "enabled");

    // R4 acknowledge
    cur_req = "R4";
    idle(); ack = 8'h02; step();
    idle(); read_expect("R4", 8'h00);
    gie = 0; mask = 8'h00;

    // R8 set wins over write and ack
    cur_req = "R8";
    pin = 8'h00; step();
    pin = 8'h08; ack = 8'h08; wr = 1; addr = 8'h1C; wdata = 8'h08; step();
    read_expect("R8", 8'h08);
    clear_all();

    // R6 level setting
    cur_req = "R6";
    pin = 8'h00; step();
    pin = 8'h01; step();
    sense = 16'hFFFC; pin = 8'h00; step();
    read_expect("R6", 8'h00);
    gie = 1; mask = 8'h01; step(); step();
    check("R6", irq, 8'h01, "level low request");
    pin = 8'h01; step(); step();
    check("R6", irq, 8'h00, "level high no request");
    gie = 0; mask = 8'h00;

    // R7 sleep gating on lines 3..0
    cur_req = "R7";
    sense = 16'hAAAA; pin = 8'hFF; step(); step();
    clear_all();
    sleep = 1; step();
    read_expect("R7", 8'h0F);
    clear_all();
    sleep = 0; step();
    mask = 8'h0F; sleep = 1; step();
    read_expect("R7", 8'h00);
    sleep = 0; mask = 8'h00; clear_all();

    // random mix, checked every clock
    cur_req = "R2";
    for (int n = 0; n < 600; n++) begin
      pin   = $urandom;
      sense = (n % 50 < 10) ? 16'($urandom) : sense;
      sleep = ($urandom % 4) == 0;
      mask  = $urandom;
      gie   = $urandom;
      ack   = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
      wr    = ($urandom % 4) == 0;
      rd    = ($urandom % 2) == 0;
      addr  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h1C;
      wdata = $urandom;
      step();
    end
    idle();
    step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule